// File: doc/BRIEF.md
# Interlaced Even-Field Vertical Sync Delay

This block sits on the vertical sync line of a display timing path. In interlaced operation it can hold back the vertical sync pulse of every even field by a programmable number of dot clocks. Both edges of the pulse move by the same amount, so the pulse keeps its width. In every other case the pulse goes through with only the block's single output register in the way. That case covers progressive timing, odd fields, the enable clear, and a count of zero.

The delay that applies to a pulse is fixed at the dot clock edge where its rising edge is first seen. At that edge the block takes the mode flag, the field parity, the enable and the 12-bit count, and the result is held for the whole pulse. Changes to these controls while a pulse is in flight reach only the next pulse. Two down-counters time the edges, one per edge direction, so the block needs no 4096-stage delay line. The controls and the sync signal are plain level pins. There is no data stream and so no valid/ready handshake or back-pressure.

The sync source must respect two limits. It must hold the line low for more than N+1 clocks between pulses, where N is the delay of the pulse that just ended. It must also start no pulse while the previous rising edge is still pending. A pulse narrower than N is allowed.

Top module: `vsync_field_delay`

## Requirements
- R1: After reset `vsync_out` is low and no edge is pending.
- R2: With `shift_en` low, `vsync_out` equals `vsync_in` one clock later, whatever the count.
- R3: With `interlaced` low (progressive), `vsync_out` equals `vsync_in` one clock later.
- R4: With `field_even` low (odd field), `vsync_out` equals `vsync_in` one clock later.
- R5: With `shift_en`, `interlaced` and `field_even` all high and count N, each edge of `vsync_in` appears on `vsync_out` after N+1 clocks.
- R6: The delayed output pulse is exactly as wide, in clocks, as the input pulse.
- R7: A count of zero with the delay otherwise selected behaves exactly as the pass-through of R2.
- R8: The delay of a pulse is set by the controls sampled with its rising edge. Changing `shift_cnt`, `field_even`, `interlaced` or `shift_en` during the pulse leaves its falling edge where it was.
- R9: A pulse narrower than its delay N is still reproduced with correct position and width.
- R10: The largest count, 4095, delays the pulse by 4096 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_in | input | 1 | Raw vertical sync, active high |
| interlaced | input | 1 | High when the timing is interlaced |
| field_even | input | 1 | High during an even field |
| shift_en | input | 1 | Enables the even-field delay |
| shift_cnt | input | 12 | Delay in dot clocks |
| vsync_out | output | 1 | Adjusted vertical sync |

## Verification
Some properties hold on every clock and are checked by assertions there. Each counter steps down by one per clock while it is armed, and an armed counter never holds zero. The two edge timers never fire in the same clock. The output changes only when a timer fires, and the latched delay moves only at a rising edge. Only the bench scenarios can show that the pulse lands in the right place for each combination of mode, parity and enable, that its width survives, and that changing the controls in mid-pulse has no effect. The bench sweeps the counts, the pulse widths and every control combination and compares each cycle against an arithmetic model.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [0:0] {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
  localparam int NUM_EDGES = 2;
endpackage

// File: rtl/vsd_edge_detect.sv
module vsd_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
  assign fall = ~sig_in & sig_q;

  a_r6_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
endmodule

// File: rtl/vsd_edge_timer.sv
module vsd_edge_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] dly,
  output logic             fire,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;
  logic             busy_q;

  // Fire at once for a zero delay, else when the count reaches its last step.
  assign fire = load ? (dly == '0) : (busy_q && cnt == CNT_W'(1));
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      cnt    <= dly;
      busy_q <= (dly != '0);
    end else if (busy_q) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  // R5: an armed counter steps down by exactly one per clock
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !load && cnt != CNT_W'(1)) |=> (busy_q && cnt == $past(cnt) - CNT_W'(1)));
  // R10: an armed counter never holds zero, even at the largest count
  a_r10_armed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt != '0));
  // R1: the counter disarms after its last step
  a_r1_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !load && cnt == CNT_W'(1)) |=> !busy_q);
endmodule

// File: rtl/vsync_field_delay.sv
module vsync_field_delay #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_in,
  input  logic             interlaced,
  input  logic             field_even,
  input  logic             shift_en,
  input  logic [CNT_W-1:0] shift_cnt,
  output logic             vsync_out
);
  import vsd_pkg::*;

  logic             rise_evt, fall_evt;
  logic [CNT_W-1:0] eff_dly, dly_lat;
  logic             delay_sel;
  logic [NUM_EDGES-1:0]            t_load, t_fire, t_busy;
  logic [NUM_EDGES-1:0][CNT_W-1:0] t_dly;
  logic             out_q;

  vsd_edge_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_in(vsync_in),
    .rise  (rise_evt),
    .fall  (fall_evt)
  );

  assign delay_sel = shift_en & interlaced & field_even;
  assign eff_dly   = delay_sel ? shift_cnt : '0;

  // The delay chosen at the rising edge is kept for the falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dly_lat <= '0;
    else if (rise_evt) dly_lat <= eff_dly;
  end

  assign t_load[EDGE_RISE] = rise_evt;
  assign t_dly[EDGE_RISE]  = eff_dly;
  assign t_load[EDGE_FALL] = fall_evt;
  assign t_dly[EDGE_FALL]  = dly_lat;

  for (genvar g = 0; g < NUM_EDGES; g++) begin : g_timer
    vsd_edge_timer #(.CNT_W(CNT_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (t_load[g]),
      .dly  (t_dly[g]),
      .fire (t_fire[g]),
      .busy (t_busy[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 out_q <= 1'b0;
    else if (t_fire[EDGE_RISE]) out_q <= 1'b1;
    else if (t_fire[EDGE_FALL]) out_q <= 1'b0;
  end

  assign vsync_out = out_q;

  // R5: a firing rise timer raises the output on the next clock
  a_r5_rise_sets_out: assert property (@(posedge clk) disable iff (!rst_n)
    t_fire[EDGE_RISE] |=> vsync_out);
  // R6: a firing fall timer lowers the output on the next clock
  a_r6_fall_clears_out: assert property (@(posedge clk) disable iff (!rst_n)
    (t_fire[EDGE_FALL] && !t_fire[EDGE_RISE]) |=> !vsync_out);
  // R6: the output moves only when a timer fires
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (t_fire == '0) |=> $stable(vsync_out));
  // R9: the two edge timers never fire together under legal spacing
  a_r9_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
    !(t_fire[EDGE_RISE] && t_fire[EDGE_FALL]));
  // R8: the latched delay changes only at a rising edge
  a_r8_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(dly_lat));
  // R7: a zero effective delay passes the rising edge with one register stage
  a_r7_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && eff_dly == '0) |=> vsync_out);
endmodule

// File: tb/tb_vsync_field_delay.sv
module tb_vsync_field_delay;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             vsync_in = 1'b0;
  logic             interlaced = 1'b0;
  logic             field_even = 1'b0;
  logic             shift_en = 1'b0;
  logic [CNT_W-1:0] shift_cnt = '0;
  logic             vsync_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vsync_field_delay #(.CNT_W(CNT_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync_in  (vsync_in),
    .interlaced(interlaced),
    .field_even(field_even),
    .shift_en  (shift_en),
    .shift_cnt (shift_cnt),
    .vsync_out (vsync_out)
  );

  function automatic int exp_delay(bit il, bit ev, bit en, int n);
    return (il && ev && en) ? n : 0;
  endfunction

  // One pulse of width w, then g low cycles. Output at step k is expected
  // high when d <= k < w + d (input seen at posedge 0, one register stage).
  // With mid set, the controls are scrambled after the first step (R8).
  task automatic run_pulse(bit il, bit ev, bit en, int n, int w, int g,
                           bit mid, string req);
    int d;
    int bad;
    int first_k;
    logic act;
    logic exp;
    d = exp_delay(il, ev, en, n);
    bad = 0;
    first_k = -1;
    act = 1'b0;
    exp = 1'b0;
    @(negedge clk);
    interlaced = il; field_even = ev; shift_en = en; shift_cnt = CNT_W'(n);
    for (int k = 0; k < w + g; k++) begin
      vsync_in = (k < w);
      @(negedge clk);
      if (mid && k == 0) begin
        interlaced = ~il; field_even = ~ev; shift_en = ~en;
        shift_cnt = CNT_W'(n + 3);
      end
      if (vsync_out !== ((k >= d) && (k < w + d)) && first_k < 0) begin
        first_k = k; act = vsync_out; exp = ((k >= d) && (k < w + d));
      end
      if (vsync_out !== ((k >= d) && (k < w + d))) bad++;
    end
    vsync_in = 1'b0;
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s il=%0b ev=%0b en=%0b n=%0d w=%0d: step %0d actual=%0b expected=%0b (%0d bad steps)",
               req, il, ev, en, n, w, first_k, act, exp, bad);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int widths[4];
    int counts[5];
    widths = '{1, 2, 5, 10};
    counts = '{0, 1, 2, 3, 7};
    repeat (3) @(negedge clk);
    // R1: output low while in reset and right after release
    tests++;
    if (vsync_out !== 1'b0) begin
      fails++; $display("FAIL R1 in reset: actual=%0b expected=0", vsync_out);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    tests++;
    if (vsync_out !== 1'b0) begin
      fails++; $display("FAIL R1 after reset: actual=%0b expected=0", vsync_out);
    end

    // Sweep of every control combination (R2, R3, R4, R5, R6, R7, R9)
    for (int m = 0; m < 8; m++) begin
      for (int ci = 0; ci < 5; ci++) begin
        for (int wi = 0; wi < 4; wi++) begin
          string tag;
          if (m[2] == 1'b0)      tag = "R2";
          else if (m[0] == 1'b0) tag = "R3";
          else if (m[1] == 1'b0) tag = "R4";
          else if (counts[ci] == 0) tag = "R7";
          else if (widths[wi] < counts[ci]) tag = "R9";
          else tag = "R5_R6";
          run_pulse(m[0], m[1], m[2], counts[ci], widths[wi],
                    counts[ci] + 4, 1'b0, tag);
        end
      end
    end

    // R8: controls changed during the pulse, both delayed and pass-through
    run_pulse(1'b1, 1'b1, 1'b1, 5, 8, 10, 1'b1, "R8");
    run_pulse(1'b1, 1'b1, 1'b1, 2, 6, 8, 1'b1, "R8");
    run_pulse(1'b1, 1'b0, 1'b1, 4, 6, 10, 1'b1, "R8");
    run_pulse(1'b0, 1'b1, 1'b0, 6, 9, 12, 1'b1, "R8");

    // R10: largest count, narrow and wide pulses
    run_pulse(1'b1, 1'b1, 1'b1, 4095, 3, 4100, 1'b0, "R10");
    run_pulse(1'b1, 1'b1, 1'b1, 4095, 4200, 4100, 1'b0, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule